// File: doc/BRIEF.md
# Round-Robin Random Word Distributor

This block shares a single random-word source among a fixed number of consumer ports. The source offers at most one word per cycle through a valid/ready pair. Each consumer port has its own small prefetch FIFO. The distributor tops up these FIFOs in rotating order, so that a consumer that asks for a word usually finds one already waiting.

A consumer reads through a get interface. The port shows a valid flag and the word at the head of its FIFO. The consumer raises its get strobe in any cycle in which it takes the word, and the word counts as consumed only when valid is high. A global disable input zeroes every delivered word while valid timing, FIFO occupancy and source consumption stay exactly as they would otherwise be. This keeps the observable timing of downstream consumers independent of the disable setting.

Top module: `rng_word_distributor`

## Requirements
- R1: Each word accepted from the source (`src_valid_i` and `src_ready_o` both high) is written into exactly one port FIFO, and at most one word is accepted per cycle.
- R2: The fill pointer resets to port 0. The accepted word goes to the first non-full port at or after the pointer, wrapping past port N-1, and the pointer then moves to the port after the one filled. A port counts as full by its occupancy at the start of the cycle, even if it is read in that same cycle.
- R3: When every port FIFO is full, `src_ready_o` is low and no source word is consumed. Otherwise `src_ready_o` is high.
- R4: Each port FIFO holds at most DEPTH words (default 2).
- R5: While `src_valid_i` is low, no word is written into any FIFO.
- R6: `valid_o[k]` is high exactly when FIFO k holds a word. `data_o[k*WIDTH +: WIDTH]` shows its oldest word. A cycle with `get_i[k]` and `valid_o[k]` both high removes that word, so words leave each port in the order they arrived.
- R7: While `disable_i` is high, every delivered data field reads zero. Valid flags, `src_ready_o` and the FIFO contents behave exactly as with `disable_i` low.
- R8: A read and a refill of the same port in the same cycle both take effect, and no word is lost or duplicated.
- R9: During reset all FIFOs are empty, all `valid_o` bits are low and `src_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Source word available |
| src_data_i | input | WIDTH | Source word |
| src_ready_o | output | 1 | Word accepted this cycle if valid |
| disable_i | input | 1 | Force delivered data to zero |
| get_i | input | N | Per-port read strobe |
| valid_o | output | N | Per-port word available |
| data_o | output | N*WIDTH | Per-port head word, port k at bits k*WIDTH +: WIDTH |

## Verification
The hardest case to reach from the ports is a refill that lands on the same port that is being read in that cycle, while other ports are full. This case tests both the skip-over of full ports and the simultaneous push and pop. The bench first fills every FIFO with no reads. It then reads a single port every cycle while the source stays valid, so the rotation must skip the full ports and every refill collides with a read. Random phases with and without disable follow. A behavioural queue model checks every port on every cycle.

// File: rtl/rng_dist_pkg.sv
package rng_dist_pkg;
  function automatic int unsigned width_of(int unsigned v);
    return (v <= 1) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/rng_word_fifo.sv
module rng_word_fifo
  import rng_dist_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned AW = width_of(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic             empty_o,
  output logic             full_o,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_pop, do_push;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & ~full_o;
  assign head_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push) wr_q <= nxt(wr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/rng_rr_pick.sv
module rng_rr_pick
  import rng_dist_pkg::*;
#(
  parameter int unsigned N = 4,
  localparam int unsigned IW = width_of(N)
) (
  input  logic [IW-1:0] ptr_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int off = 0; off < int'(N); off++) begin
      int c;
      c = int'(ptr_i) + off;
      if (c >= int'(N)) c = c - int'(N);
      if (!any_o && req_i[c]) begin
        any_o    = 1'b1;
        gnt_o[c] = 1'b1;
        idx_o    = IW'(c);
      end
    end
  end
endmodule

// File: rtl/rng_word_distributor.sv
module rng_word_distributor
  import rng_dist_pkg::*;
#(
  parameter int unsigned N     = 4,
  parameter int unsigned DEPTH = 2,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IW = width_of(N),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               src_valid_i,
  input  logic [WIDTH-1:0]   src_data_i,
  output logic               src_ready_o,
  input  logic               disable_i,
  input  logic [N-1:0]       get_i,
  output logic [N-1:0]       valid_o,
  output logic [N*WIDTH-1:0] data_o
);
  logic [N-1:0]    full_w, empty_w, gnt_w, push_w, pop_w;
  logic [N*CW-1:0] cnt_flat;
  logic [IW-1:0]   ptr_q, idx_w;
  logic            any_w, take_w;

  rng_rr_pick #(.N(N)) u_pick (
    .ptr_i (ptr_q),
    .req_i (~full_w),
    .gnt_o (gnt_w),
    .idx_o (idx_w),
    .any_o (any_w)
  );

  assign src_ready_o = any_w;
  assign take_w      = src_valid_i & any_w;
  assign push_w      = take_w ? gnt_w : '0;
  assign pop_w       = get_i & ~empty_w;
  assign valid_o     = ~empty_w;

  for (genvar k = 0; k < N; k++) begin : g_port
    logic [WIDTH-1:0] head_w;
    rng_word_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push_w[k]),
      .data_i  (src_data_i),
      .pop_i   (pop_w[k]),
      .empty_o (empty_w[k]),
      .full_o  (full_w[k]),
      .head_o  (head_w),
      .count_o (cnt_flat[k*CW +: CW])
    );
    // zero at the output so occupancy and timing are untouched
    assign data_o[k*WIDTH +: WIDTH] = disable_i ? '0 : head_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (take_w) ptr_q <= (idx_w == IW'(N - 1)) ? '0 : idx_w + IW'(1);
  end
endmodule

// File: rtl/rng_dist_chk.sv
module rng_dist_chk #(
  parameter int unsigned N     = 4,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            src_valid_i,
  input logic            src_ready_o,
  input logic [N-1:0]    push_i,
  input logic [N-1:0]    pop_i,
  input logic [N-1:0]    full_i,
  input logic [N*CW-1:0] cnt_i
);
  a_r1_single_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push_i));

  a_r3_all_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&full_i) |-> (push_i == '0) && !src_ready_o);

  a_r5_no_source_no_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_valid_i |-> (push_i == '0));

  for (genvar k = 0; k < N; k++) begin : g_k
    a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(cnt_i[k*CW +: CW]) <= int'(DEPTH));

    a_r8_count_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> int'(cnt_i[k*CW +: CW]) ==
               int'($past(cnt_i[k*CW +: CW])) + int'($past(push_i[k])) - int'($past(pop_i[k])));
  end
endmodule

bind rng_word_distributor rng_dist_chk #(.N(N), .DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_valid_i (src_valid_i),
  .src_ready_o (src_ready_o),
  .push_i      (push_w),
  .pop_i       (pop_w),
  .full_i      (full_w),
  .cnt_i       (cnt_flat)
);

// File: tb/sim_rng_word_distributor.sv
module sim_rng_word_distributor;
  localparam int NP = 4;
  localparam int D  = 2;
  localparam int W  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sv = 1'b0;
  logic [W-1:0]    sd = '0;
  logic            src_rdy;
  logic            dis = 1'b0;
  logic [NP-1:0]   get = '0;
  logic [NP-1:0]   vld;
  logic [NP*W-1:0] dat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] mq [NP][$];
  int mptr = 0;

  always #2 clk = ~clk;

  rng_word_distributor #(.N(NP), .DEPTH(D), .WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_valid_i(sv), .src_data_i(sd),
    .src_ready_o(src_rdy), .disable_i(dis), .get_i(get), .valid_o(vld), .data_o(dat)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive after negedge, compare, advance model for next posedge
  task automatic cycle(logic s_v, logic [NP-1:0] g, logic d);
    bit any;
    @(negedge clk);
    sv = s_v; sd = $urandom; get = g; dis = d;
    #1;
    any = 1'b0;
    for (int k = 0; k < NP; k++) if (mq[k].size() < D) any = 1'b1;
    chk("R3 ready", W'(src_rdy), W'(any));
    for (int k = 0; k < NP; k++) begin
      chk("R6 valid", W'(vld[k]), W'(mq[k].size() > 0));
      if (mq[k].size() > 0) begin
        if (d) chk("R7 zero data", dat[k*W +: W], '0);
        else   chk("R6/R2/R8 data", dat[k*W +: W], mq[k][0]);
      end
    end
    begin
      int g_idx;
      g_idx = -1;
      if (s_v) begin
        for (int off = 0; off < NP; off++) begin
          int c;
          c = (mptr + off) % NP;
          if (g_idx < 0 && mq[c].size() < D) g_idx = c;
        end
      end
      for (int k = 0; k < NP; k++)
        if (g[k] && mq[k].size() > 0) void'(mq[k].pop_front());
      if (g_idx >= 0) begin
        mq[g_idx].push_back(sd);
        mptr = (g_idx + 1) % NP;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R9 valid in reset", W'(vld), '0);
    chk("R9 ready in reset", W'(src_rdy), W'(1));
    @(negedge clk); rst_n = 1'b1;
    // R5: no source words
    for (int i = 0; i < 10; i++) cycle(1'b0, NP'($urandom), 1'b0);
    // R2/R3/R4: fill in order with no reads, then stall
    for (int i = 0; i < 12; i++) cycle(1'b1, '0, 1'b0);
    // R8: single reader while others full
    for (int i = 0; i < 60; i++) cycle(1'b1, NP'(4), 1'b0);
    // R1/R2/R6 random mix
    for (int i = 0; i < 300; i++) cycle(1'($urandom), NP'($urandom), 1'b0);
    // R7 disable with identical timing model
    for (int i = 0; i < 150; i++) cycle(1'($urandom), NP'($urandom), 1'b1);
    for (int i = 0; i < 100; i++) cycle(1'b1, NP'($urandom), 1'($urandom));
    for (int i = 0; i < 20; i++)  cycle(1'b0, '1, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule